// File: doc/BRIEF.md
# Scaled Convergent Rounding Unit

This block rounds a 56-bit fixed-point accumulator, presented as an 8-bit extension byte, a 24-bit upper word and a 24-bit lower word. The rounding point moves with a 2-bit scaling selector: with no scaling the result keeps the full upper word, with scale-down it keeps the upper word with its lowest bit dropped, and with scale-up it keeps the upper word plus the top bit of the lower word. Everything below the kept part is cleared.

A single mode input chooses between convergent rounding, where an exact half goes to the nearest even kept value, and two's-complement rounding, where an exact half always goes up. The carry from the rounding increment ripples through the upper word into the extension byte, and the whole value wraps within 56 bits. The arithmetic is combinational; an output register, present by default, captures the result on a valid strobe and holds it until the next one.

Top module: `scaled_round_unit`

## Requirements
- R1: `round_twos` = 0 selects convergent rounding (exact half to even); `round_twos` = 1 selects two's-complement rounding (exact half rounds up, e.g. upper 0x400000 with lower 0x800000 gives 0x400001 with no scaling).
- R2: `scale_sel` encodes 0 = no scaling, 1 = scale-down, 2 = scale-up; the code 3 gives exactly the result of code 0.
- R3: With no scaling, 2^23 is added and the whole lower word is cleared; upper 0x400000 with lower 0x800001 gives 0x400001, and with lower 0x7FFFFF stays 0x400000.
- R4: With no scaling under convergent rounding, an exact half leaves upper bit 0 at zero: 0x400000/0x800000 stays 0x400000, 0x400001/0x800000 becomes 0x400002.
- R5: With scale-down, 2^24 is added, the lower word and bit 0 of the upper word are cleared.
- R6: With scale-down under convergent rounding, when the bits below the kept part (upper bit 0 and the lower word) are zero after the increment, upper bit 1 is cleared.
- R7: With scale-up, 2^22 is added and only bit 23 of the lower word survives.
- R8: With scale-up under convergent rounding, when lower bits 22..0 are zero after the increment, lower bit 23 is cleared too.
- R9: The increment carries into the extension byte, and a carry out of bit 55 is dropped (the result wraps within 56 bits).
- R10: With the output register, a result taken while `in_valid` is high appears on the outputs one clock later with `res_valid` high; while `in_valid` is low the outputs hold and `res_valid` is low the next cycle.
- R11: While `rst_n` is low, `res_valid` and all result bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for the output register |
| round_twos | input | 1 | 0 = convergent, 1 = two's-complement rounding |
| scale_sel | input | 2 | Scaling selector (0 none, 1 down, 2 up, 3 as none) |
| acc_ext | input | 8 | Extension byte of the accumulator |
| acc_hi | input | 24 | Upper word of the accumulator |
| acc_lo | input | 24 | Lower word of the accumulator |
| res_valid | output | 1 | Result present on the outputs |
| res_ext | output | 8 | Rounded extension byte |
| res_hi | output | 24 | Rounded upper word |
| res_lo | output | 24 | Rounded lower word (cleared below the rounding point) |

## Verification
The bench builds the block with its default widths (8/24/24) and with the output register in place, so every result is observed one clock after its strobe and the hold behaviour between strobes is reachable. With these widths the directed cases can hit the exact-half ties in each scaling mode, an increment that carries through a full upper word into the extension byte, and the wrap from an all-ones accumulator to zero. Random vectors with forced low-bit patterns spread ties and near-ties across all four selector codes and both rounding modes.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    SC_NONE  = 2'd0,
    SC_DOWN  = 2'd1,
    SC_UP    = 2'd2,
    SC_ALIAS = 2'd3
  } scale_e;

  localparam int LANES = 3;

  // Lane index that serves a given selector code; code 3 reuses lane 0.
  function automatic int lane_of(input scale_e s);
    case (s)
      SC_DOWN: return 1;
      SC_UP:   return 2;
      default: return 0;
    endcase
  endfunction

  // Position of the half-unit increment for a lane with a lower word of lo_w bits.
  function automatic int half_pos(input int lane, input int lo_w);
    case (lane)
      1:       return lo_w;
      2:       return lo_w - 2;
      default: return lo_w - 1;
    endcase
  endfunction

endpackage

// File: rtl/rnd_lane.sv
module rnd_lane #(
  parameter int EXT_W = 8,
  parameter int HI_W  = 24,
  parameter int LO_W  = 24,
  parameter int LANE  = 0,
  localparam int ACC_W = EXT_W + HI_W + LO_W
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             conv,
  output logic [ACC_W-1:0] res,
  output logic             tie
);
  localparam int RPOS = rnd_pkg::half_pos(LANE, LO_W);
  localparam int UPOS = RPOS + 1;

  function automatic logic [ACC_W-1:0] add_half(input logic [ACC_W-1:0] v);
    return v + (ACC_W'(1) << RPOS);
  endfunction

  function automatic logic below_zero(input logic [ACC_W-1:0] s);
    return s[RPOS:0] == '0;
  endfunction

  function automatic logic [ACC_W-1:0] trim(input logic [ACC_W-1:0] s,
                                            input logic clr_unit);
    logic [ACC_W-1:0] r;
    r = s;
    if (clr_unit) r[UPOS] = 1'b0;
    r[RPOS:0] = '0;
    return r;
  endfunction

  logic [ACC_W-1:0] sum;

  always_comb begin
    sum = add_half(acc);
    tie = below_zero(sum);
    res = trim(sum, conv & tie);
  end
endmodule

// File: rtl/rnd_select.sv
module rnd_select
  import rnd_pkg::*;
#(
  parameter int ACC_W = 56
) (
  input  logic [ACC_W-1:0] lane_res [LANES],
  input  logic             lane_tie [LANES],
  input  scale_e           sel,
  output logic [ACC_W-1:0] out_res,
  output logic             out_tie
);
  always_comb begin
    out_res = lane_res[lane_of(sel)];
    out_tie = lane_tie[lane_of(sel)];
  end
endmodule

// File: rtl/rnd_hold.sv
module rnd_hold #(
  parameter int W       = 56,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q       <= '0;
          q_valid <= 1'b0;
        end else begin
          q_valid <= load;
          if (load) q <= d;
        end
      end
    end else begin : g_wire
      assign q       = d;
      assign q_valid = load;
    end
  endgenerate
endmodule

// File: rtl/scaled_round_unit.sv
module scaled_round_unit
  import rnd_pkg::*;
#(
  parameter int EXT_W   = 8,
  parameter int HI_W    = 24,
  parameter int LO_W    = 24,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             round_twos,
  input  logic [1:0]       scale_sel,
  input  logic [EXT_W-1:0] acc_ext,
  input  logic [HI_W-1:0]  acc_hi,
  input  logic [LO_W-1:0]  acc_lo,
  output logic             res_valid,
  output logic [EXT_W-1:0] res_ext,
  output logic [HI_W-1:0]  res_hi,
  output logic [LO_W-1:0]  res_lo
);
  localparam int ACC_W = EXT_W + HI_W + LO_W;

  // Named internal events, brought out for the checker.
  logic [ACC_W-1:0] acc_word;
  logic             conv_mode;
  logic [ACC_W-1:0] lane_res [LANES];
  logic             lane_tie [LANES];
  logic [ACC_W-1:0] comb_res;
  logic             comb_tie;
  logic [ACC_W-1:0] held_res;

  assign acc_word  = {acc_ext, acc_hi, acc_lo};
  assign conv_mode = ~round_twos;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      rnd_lane #(
        .EXT_W(EXT_W),
        .HI_W (HI_W),
        .LO_W (LO_W),
        .LANE (g)
      ) u_lane (
        .acc (acc_word),
        .conv(conv_mode),
        .res (lane_res[g]),
        .tie (lane_tie[g])
      );
    end
  endgenerate

  rnd_select #(.ACC_W(ACC_W)) u_sel (
    .lane_res(lane_res),
    .lane_tie(lane_tie),
    .sel     (scale_e'(scale_sel)),
    .out_res (comb_res),
    .out_tie (comb_tie)
  );

  rnd_hold #(.W(ACC_W), .REG_OUT(REG_OUT)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (in_valid),
    .d      (comb_res),
    .q_valid(res_valid),
    .q      (held_res)
  );

  assign {res_ext, res_hi, res_lo} = held_res;
endmodule

// File: rtl/rnd_checker.sv
module rnd_checker #(
  parameter int EXT_W   = 8,
  parameter int HI_W    = 24,
  parameter int LO_W    = 24,
  parameter bit REG_OUT = 1'b1,
  localparam int ACC_W = EXT_W + HI_W + LO_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       scale_sel,
  input logic             conv_mode,
  input logic [ACC_W-1:0] comb_res,
  input logic             comb_tie,
  input logic             res_valid,
  input logic [ACC_W-1:0] held_res
);
  logic md_none, md_down, md_up;
  assign md_none = (scale_sel == 2'd0);
  assign md_down = (scale_sel == 2'd1);
  assign md_up   = (scale_sel == 2'd2);

  assert_lo_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    md_none |-> comb_res[LO_W-1:0] == '0);

  assert_alias_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_sel == 2'd3) |-> comb_res[LO_W-1:0] == '0);

  assert_tie_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (md_none && conv_mode && comb_tie) |-> !comb_res[LO_W]);

  assert_down_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    md_down |-> comb_res[LO_W:0] == '0);

  assert_tie_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (md_down && conv_mode && comb_tie) |-> !comb_res[LO_W+1]);

  assert_up_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    md_up |-> comb_res[LO_W-2:0] == '0);

  assert_tie_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (md_up && conv_mode && comb_tie) |-> !comb_res[LO_W-1]);

  generate
    if (REG_OUT) begin : g_reg_chk
      assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
      assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
      assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(held_res));
      assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> held_res == $past(comb_res));
    end
  endgenerate
endmodule

bind scaled_round_unit rnd_checker #(
  .EXT_W  (EXT_W),
  .HI_W   (HI_W),
  .LO_W   (LO_W),
  .REG_OUT(REG_OUT)
) u_rnd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .scale_sel(scale_sel),
  .conv_mode(conv_mode),
  .comb_res (comb_res),
  .comb_tie (comb_tie),
  .res_valid(res_valid),
  .held_res (held_res)
);

// File: tb/test_scaled_round_unit.sv
module test_scaled_round_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        round_twos = 1'b0;
  logic [1:0]  scale_sel = 2'd0;
  logic [7:0]  acc_ext = '0;
  logic [23:0] acc_hi = '0;
  logic [23:0] acc_lo = '0;
  logic        res_valid;
  logic [7:0]  res_ext;
  logic [23:0] res_hi;
  logic [23:0] res_lo;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scaled_round_unit i_scaled_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .round_twos(round_twos),
    .scale_sel(scale_sel), .acc_ext(acc_ext), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .res_valid(res_valid), .res_ext(res_ext), .res_hi(res_hi), .res_lo(res_lo)
  );

  // Reference: quotient/remainder view of rounding at a kept-unit boundary.
  function automatic logic [55:0] ref_round(input logic [55:0] v, input int code,
                                            input bit twos);
    int sh;
    logic [63:0] q, rem, half;
    sh   = (code == 1) ? 25 : (code == 2) ? 23 : 24;
    q    = {8'h0, v} >> sh;
    rem  = {8'h0, v} & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && (twos || q[0]))) q = q + 64'd1;
    return 56'(q << sh);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Drive one vector at a falling edge, check it one clock later.
  task automatic run_vec(input string tag, input logic [55:0] v, input int code,
                         input bit twos, input logic [55:0] exp);
    @(negedge clk);
    {acc_ext, acc_hi, acc_lo} = v;
    scale_sel  = 2'(code);
    round_twos = twos;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, {res_ext, res_hi, res_lo}, exp);
    chk({tag, " valid R10"}, res_valid, 1'b1);
  endtask

  task automatic run_ref(input string tag, input logic [55:0] v, input int code,
                         input bit twos);
    run_vec(tag, v, code, twos, ref_round(v, code, twos));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [55:0] prev;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 result", {res_ext, res_hi, res_lo}, 56'h0);
    chk("R11 valid", res_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: no scaling, round up / down
    run_vec("R3 up",   {8'h00, 24'h400000, 24'h800001}, 0, 1'b0, {8'h00, 24'h400001, 24'h0});
    run_vec("R3 down", {8'h00, 24'h400000, 24'h7FFFFF}, 0, 1'b0, {8'h00, 24'h400000, 24'h0});
    // R4: ties to even
    run_vec("R4 even", {8'h00, 24'h400000, 24'h800000}, 0, 1'b0, {8'h00, 24'h400000, 24'h0});
    run_vec("R4 odd",  {8'h00, 24'h400001, 24'h800000}, 0, 1'b0, {8'h00, 24'h400002, 24'h0});
    // R1: two's-complement tie goes up
    run_vec("R1 tie",  {8'h00, 24'h400000, 24'h800000}, 0, 1'b1, {8'h00, 24'h400001, 24'h0});
    // R2: code 3 equals code 0
    run_vec("R2 alias", {8'h00, 24'h400001, 24'h800000}, 3, 1'b0, {8'h00, 24'h400002, 24'h0});
    // R5/R6: scale-down
    run_vec("R5 up",   {8'h00, 24'h400001, 24'h000001}, 1, 1'b0, {8'h00, 24'h400002, 24'h0});
    run_vec("R6 even", {8'h00, 24'h400001, 24'h000000}, 1, 1'b0, {8'h00, 24'h400000, 24'h0});
    run_vec("R6 odd",  {8'h00, 24'h400003, 24'h000000}, 1, 1'b0, {8'h00, 24'h400004, 24'h0});
    run_vec("R1 down tie", {8'h00, 24'h400001, 24'h000000}, 1, 1'b1, {8'h00, 24'h400002, 24'h0});
    // R7/R8: scale-up
    run_vec("R7 up",   {8'h00, 24'h400000, 24'h400001}, 2, 1'b0, {8'h00, 24'h400000, 24'h800000});
    run_vec("R8 even", {8'h00, 24'h400000, 24'h400000}, 2, 1'b0, {8'h00, 24'h400000, 24'h000000});
    run_vec("R8 odd",  {8'h00, 24'h400000, 24'hC00000}, 2, 1'b0, {8'h00, 24'h400001, 24'h000000});
    run_vec("R1 up tie", {8'h00, 24'h400000, 24'h400000}, 2, 1'b1, {8'h00, 24'h400000, 24'h800000});
    // R9: carry into extension and wrap
    run_vec("R9 carry", {8'h00, 24'hFFFFFF, 24'h800000}, 0, 1'b1, {8'h01, 24'h000000, 24'h0});
    run_vec("R9 wrap",  {8'hFF, 24'hFFFFFF, 24'hFFFFFF}, 0, 1'b0, 56'h0);

    // R10: hold while in_valid low
    prev = {res_ext, res_hi, res_lo};
    @(negedge clk);
    {acc_ext, acc_hi, acc_lo} = {8'h12, 24'h345678, 24'h9ABCDE};
    scale_sel = 2'd1;
    @(negedge clk);
    chk("R10 hold", {res_ext, res_hi, res_lo}, prev);
    chk("R10 valid low", res_valid, 1'b0);

    // Random vectors, low bits sometimes forced to near-tie patterns
    for (int i = 0; i < 3000; i++) begin
      logic [55:0] v;
      int code;
      bit twos;
      v    = {$urandom(), $urandom()} & 56'hFF_FFFFFF_FFFFFF;
      code = int'($urandom_range(0, 3));
      twos = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 3))
        0: v[24:0] = 25'($urandom_range(0, 1)) << 24;
        1: v[23:0] = 24'h800000;
        2: v[22:0] = 23'h400000;
        default: ;
      endcase
      case (code)
        1: run_ref(twos ? "R1 R5 rand" : "R6 rand", v, code, twos);
        2: run_ref(twos ? "R1 R7 rand" : "R8 rand", v, code, twos);
        3: run_ref("R2 rand", v, code, twos);
        default: run_ref(twos ? "R1 R3 rand" : "R4 rand", v, code, twos);
      endcase
    end

    summary();
  end
endmodule